// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block converts a 32-bit virtual address into a physical address. It does this by reading descriptors from a translation table that lives in ordinary memory. A lookup is accepted on a request port. The block then issues one or two word reads on a simple memory read master port. It answers with a one-cycle response that carries the physical address, a page-size code and a fault flag.

The first read selects a 1 MB slice of the address space. That descriptor either finishes the walk itself, as a 1 MB section or a 16 MB supersection, or points to a 256-entry second-level table that maps 64 KB or 4 KB pages.

A table base input gives the location of the first-level table, which is 16 KB and aligned to 16 KB. An enable input picks between table translation and a flat mapping. The enable value is taken at the moment a request is accepted. Results are not cached, and every lookup walks the table again.

Top module: `xlat_walker`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_valid_o` is 0.
- R2: A request accepted while `en_i` is 0 makes no memory read. It responds in the cycle after acceptance with `rsp_pa_o` equal to the virtual address, size code 4 (flat) and no fault.
- R3: With `en_i` at 1, the first read address is `{tbl_base_i[31:14], va[31:20], 2'b00}`. Base bits [13:0] have no effect.
- R4: A first-level descriptor whose bits [1:0] are 00 ends the walk after one read. The response has the fault flag set, `rsp_pa_o` = 0 and size code 0.
- R5: A first-level descriptor whose bits [1:0] are 11 is also answered as a fault, with `rsp_pa_o` = 0, size code 0 and one read only.
- R6: A first-level descriptor of type 10 with bit 18 clear ends the walk after one read. It gives `rsp_pa_o = {desc[31:20], va[19:0]}` with size code 2.
- R7: A first-level descriptor of type 10 with bit 18 set is a 16 MB mapping. It gives `rsp_pa_o = {desc[31:24], va[23:0]}` with size code 3, after one read.
- R8: A first-level descriptor of type 01 starts a second read at address `{desc[31:10], va[19:12], 2'b00}`.
- R9: A second-level descriptor of type 10 (bits [1:0]) is a 4 KB page. It gives `rsp_pa_o = {desc[31:12], va[11:0]}` with size code 0 and no fault.
- R10: A second-level descriptor of type 01 is a 64 KB page. It gives `rsp_pa_o = {desc[31:16], va[15:0]}` with size code 1 and no fault.
- R11: A second-level descriptor of type 00 or 11 is answered as a fault, with `rsp_pa_o` = 0 and size code 0.
- R12: `mem_req_valid_o` and `mem_addr_o` stay steady while a read waits for `mem_req_ready_i`. A lookup makes at most two reads. `req_ready_o` is 0 while a walk is in progress. Each lookup yields exactly one single-cycle `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | 1 = translate through the table, 0 = flat mapping; sampled at request acceptance |
| tbl_base_i | input | 32 | First-level table location; bits [13:0] ignored |
| req_valid_i | input | 1 | Lookup request valid |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Block idle and able to accept a lookup |
| rsp_valid_o | output | 1 | One-cycle pulse: response fields valid |
| rsp_pa_o | output | 32 | Physical address (0 on fault) |
| rsp_size_o | output | 3 | 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB, 4 = flat |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read this cycle |
| mem_addr_o | output | 32 | Word address of the descriptor read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word returned by memory |

## Verification
The bound checker checks, on every cycle, these properties:
- a flat lookup never touches memory and returns its own address;
- the first read address is formed from the base and the top index bits;
- section results come after exactly one read and page results after exactly two;
- faults carry a zero address;
- a stalled read holds its address;
- responses are single pulses.

Only the bench scenarios show the following:
- the physical address assembled for each descriptor type from chosen descriptor words;
- the second-level address taken from a real descriptor;
- that type 11 at either level faults;
- that base bits [13:0] have no effect;
- the response latency of a flat lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      SZ_SMALL   = 3'd0,
      SZ_LARGE   = 3'd1,
      SZ_SECTION = 3'd2,
      SZ_SUPER   = 3'd3,
      SZ_FLAT    = 3'd4
   } pg_size_e;

   typedef enum logic [1:0] {
      L1K_FAULT = 2'd0,
      L1K_LEAF  = 2'd1,
      L1K_TABLE = 2'd2
   } l1_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_RESP    = 3'd5
   } walk_st_e;

   localparam logic [1:0] L1_TYPE_TABLE   = 2'b01;
   localparam logic [1:0] L1_TYPE_SECTION = 2'b10;
   localparam logic [1:0] L2_TYPE_LARGE   = 2'b01;
   localparam logic [1:0] L2_TYPE_SMALL   = 2'b10;

   localparam int RES_PA_W = 32;

   typedef struct packed {
      logic                fault;
      pg_size_e            size;
      logic [RES_PA_W-1:0] pa;
   } xlat_res_t;

endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
   import xlat_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEC_SHIFT = 20,
   parameter int SS_SHIFT  = 24,
   parameter int SS_BIT    = 18,
   parameter bit SS_EN     = 1'b1
) (
   input  logic [ADDR_W-1:0] desc_i,
   input  logic [ADDR_W-1:0] va_i,
   output l1_kind_e          kind_o,
   output xlat_res_t         res_o
);

   localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} << SEC_SHIFT;
   localparam logic [ADDR_W-1:0] SS_MASK  = {ADDR_W{1'b1}} << SS_SHIFT;

   generate
      if (SS_BIT < 2 || SS_BIT >= SEC_SHIFT) begin : g_bad_ss_bit
         $error("xlat_l1_dec: SS_BIT must lie between the type field and the section base");
      end
      if (SS_SHIFT <= SEC_SHIFT || SS_SHIFT >= ADDR_W) begin : g_bad_ss_shift
         $error("xlat_l1_dec: SS_SHIFT must exceed SEC_SHIFT and stay below ADDR_W");
      end
   endgenerate

   logic ss_sel;

   generate
      if (SS_EN) begin : g_ss
         assign ss_sel = desc_i[SS_BIT];
      end else begin : g_no_ss
         assign ss_sel = 1'b0;
      end
   endgenerate

   logic [ADDR_W-1:0] sec_pa;
   logic [ADDR_W-1:0] ss_pa;

   assign sec_pa = (desc_i & SEC_MASK) | (va_i & ~SEC_MASK);
   assign ss_pa  = (desc_i & SS_MASK)  | (va_i & ~SS_MASK);

   always_comb begin
      kind_o       = L1K_FAULT;
      res_o.fault  = 1'b1;
      res_o.size   = SZ_SMALL;
      res_o.pa     = '0;
      case (desc_i[1:0])
         L1_TYPE_TABLE: begin
            kind_o      = L1K_TABLE;
            res_o.fault = 1'b0;
         end
         L1_TYPE_SECTION: begin
            kind_o      = L1K_LEAF;
            res_o.fault = 1'b0;
            if (ss_sel) begin
               res_o.size = SZ_SUPER;
               res_o.pa   = ss_pa;
            end else begin
               res_o.size = SZ_SECTION;
               res_o.pa   = sec_pa;
            end
         end
         default: begin
            kind_o      = L1K_FAULT;
            res_o.fault = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
   import xlat_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LARGE_SHIFT = 16,
   parameter int SMALL_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] desc_i,
   input  logic [ADDR_W-1:0] va_i,
   output xlat_res_t         res_o
);

   localparam logic [ADDR_W-1:0] LARGE_MASK = {ADDR_W{1'b1}} << LARGE_SHIFT;
   localparam logic [ADDR_W-1:0] SMALL_MASK = {ADDR_W{1'b1}} << SMALL_SHIFT;

   generate
      if (LARGE_SHIFT <= SMALL_SHIFT || SMALL_SHIFT < 2) begin : g_bad_shift
         $error("xlat_l2_dec: page shifts out of order");
      end
   endgenerate

   logic [ADDR_W-1:0] large_pa;
   logic [ADDR_W-1:0] small_pa;

   assign large_pa = (desc_i & LARGE_MASK) | (va_i & ~LARGE_MASK);
   assign small_pa = (desc_i & SMALL_MASK) | (va_i & ~SMALL_MASK);

   always_comb begin
      res_o.fault = 1'b1;
      res_o.size  = SZ_SMALL;
      res_o.pa    = '0;
      case (desc_i[1:0])
         L2_TYPE_SMALL: begin
            res_o.fault = 1'b0;
            res_o.size  = SZ_SMALL;
            res_o.pa    = small_pa;
         end
         L2_TYPE_LARGE: begin
            res_o.fault = 1'b0;
            res_o.size  = SZ_LARGE;
            res_o.pa    = large_pa;
         end
         default: begin
            res_o.fault = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/xlat_walk_ctl.sv
module xlat_walk_ctl
   import xlat_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_va_i,
   output logic              req_ready_o,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [ADDR_W-1:0] mem_rdata_i,
   input  l1_kind_e          l1_kind_i,
   input  xlat_res_t         l1_res_i,
   input  xlat_res_t         l2_res_i,
   output logic [ADDR_W-1:0] va_o,
   output logic              rsp_valid_o,
   output xlat_res_t         rsp_o
);

   localparam int L1_SHIFT  = ADDR_W - L1_IDX_W;
   localparam int L2_SHIFT  = L1_SHIFT - L2_IDX_W;
   localparam int L1_ALIGN  = L1_IDX_W + 2;
   localparam int L2_ALIGN  = L2_IDX_W + 2;

   walk_st_e                  state_q;
   logic [ADDR_W-1:0]         va_q;
   logic [ADDR_W-1:L2_ALIGN]  l2_tbl_q;
   xlat_res_t                 rsp_q;

   logic [ADDR_W-1:0] l1_addr;
   logic [ADDR_W-1:0] l2_addr;

   assign l1_addr = {tbl_base_i[ADDR_W-1:L1_ALIGN], va_q[ADDR_W-1:L1_SHIFT], 2'b00};
   assign l2_addr = {l2_tbl_q, va_q[L1_SHIFT-1:L2_SHIFT], 2'b00};

   logic unused_base;
   logic unused_rdata;
   assign unused_base  = ^tbl_base_i[L1_ALIGN-1:0];
   assign unused_rdata = ^mem_rdata_i[L2_ALIGN-1:0];

   assign req_ready_o     = (state_q == ST_IDLE);
   assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign mem_addr_o      = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
   assign rsp_valid_o     = (state_q == ST_RESP);
   assign rsp_o           = rsp_q;
   assign va_o            = va_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         va_q     <= '0;
         l2_tbl_q <= '0;
         rsp_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  va_q <= req_va_i;
                  if (!en_i) begin
                     rsp_q.fault <= 1'b0;
                     rsp_q.size  <= SZ_FLAT;
                     rsp_q.pa    <= req_va_i;
                     state_q     <= ST_RESP;
                  end else begin
                     state_q <= ST_L1_REQ;
                  end
               end
            end
            ST_L1_REQ: begin
               if (mem_req_ready_i) state_q <= ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
               if (mem_rvalid_i) begin
                  if (l1_kind_i == L1K_TABLE) begin
                     l2_tbl_q <= mem_rdata_i[ADDR_W-1:L2_ALIGN];
                     state_q  <= ST_L2_REQ;
                  end else begin
                     rsp_q   <= l1_res_i;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_L2_REQ: begin
               if (mem_req_ready_i) state_q <= ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
               if (mem_rvalid_i) begin
                  rsp_q   <= l2_res_i;
                  state_q <= ST_RESP;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int L1_IDX_W  = 12,
   parameter int L2_IDX_W  = 8,
   parameter int SS_SHIFT  = 24,
   parameter int SS_BIT    = 18,
   parameter int LARGE_SHIFT = 16,
   parameter bit SS_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_va_i,
   output logic              req_ready_o,
   output logic              rsp_valid_o,
   output logic [ADDR_W-1:0] rsp_pa_o,
   output logic [2:0]        rsp_size_o,
   output logic              rsp_fault_o,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [ADDR_W-1:0] mem_rdata_i
);

   localparam int SEC_SHIFT   = ADDR_W - L1_IDX_W;
   localparam int SMALL_SHIFT = SEC_SHIFT - L2_IDX_W;

   generate
      if (ADDR_W != RES_PA_W) begin : g_bad_addr_w
         $error("xlat_walker: ADDR_W must equal the result address width");
      end
      if (SMALL_SHIFT < 2) begin : g_bad_idx
         $error("xlat_walker: index widths leave no page offset");
      end
      if (LARGE_SHIFT <= SMALL_SHIFT || LARGE_SHIFT >= SEC_SHIFT) begin : g_bad_large
         $error("xlat_walker: LARGE_SHIFT must sit between page and section shifts");
      end
   endgenerate

   l1_kind_e          l1_kind;
   xlat_res_t         l1_res;
   xlat_res_t         l2_res;
   xlat_res_t         rsp;
   logic [ADDR_W-1:0] va_cur;

   xlat_walk_ctl #(
      .ADDR_W   (ADDR_W),
      .L1_IDX_W (L1_IDX_W),
      .L2_IDX_W (L2_IDX_W)
   ) u_ctl (
      .clk             (clk),
      .rst_n           (rst_n),
      .en_i            (en_i),
      .tbl_base_i      (tbl_base_i),
      .req_valid_i     (req_valid_i),
      .req_va_i        (req_va_i),
      .req_ready_o     (req_ready_o),
      .mem_req_valid_o (mem_req_valid_o),
      .mem_req_ready_i (mem_req_ready_i),
      .mem_addr_o      (mem_addr_o),
      .mem_rvalid_i    (mem_rvalid_i),
      .mem_rdata_i     (mem_rdata_i),
      .l1_kind_i       (l1_kind),
      .l1_res_i        (l1_res),
      .l2_res_i        (l2_res),
      .va_o            (va_cur),
      .rsp_valid_o     (rsp_valid_o),
      .rsp_o           (rsp)
   );

   xlat_l1_dec #(
      .ADDR_W    (ADDR_W),
      .SEC_SHIFT (SEC_SHIFT),
      .SS_SHIFT  (SS_SHIFT),
      .SS_BIT    (SS_BIT),
      .SS_EN     (SS_EN)
   ) u_l1_dec (
      .desc_i (mem_rdata_i),
      .va_i   (va_cur),
      .kind_o (l1_kind),
      .res_o  (l1_res)
   );

   xlat_l2_dec #(
      .ADDR_W      (ADDR_W),
      .LARGE_SHIFT (LARGE_SHIFT),
      .SMALL_SHIFT (SMALL_SHIFT)
   ) u_l2_dec (
      .desc_i (mem_rdata_i),
      .va_i   (va_cur),
      .res_o  (l2_res)
   );

   assign rsp_pa_o    = rsp.pa;
   assign rsp_size_o  = rsp.size;
   assign rsp_fault_o = rsp.fault;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int ADDR_W   = 32,
   parameter int L1_IDX_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic [ADDR_W-1:0] tbl_base_i,
   input logic              req_valid_i,
   input logic [ADDR_W-1:0] req_va_i,
   input logic              req_ready_o,
   input logic              rsp_valid_o,
   input logic [ADDR_W-1:0] rsp_pa_o,
   input logic [2:0]        rsp_size_o,
   input logic              rsp_fault_o,
   input logic              mem_req_valid_o,
   input logic              mem_req_ready_i,
   input logic [ADDR_W-1:0] mem_addr_o
);

   localparam int L1_SHIFT = ADDR_W - L1_IDX_W;
   localparam int L1_ALIGN = L1_IDX_W + 2;

   logic [ADDR_W-1:0] va_c;
   logic              flat_c;
   logic [1:0]        fetch_c;

   logic unused_base_lo;
   assign unused_base_lo = ^tbl_base_i[L1_ALIGN-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_c    <= '0;
         flat_c  <= 1'b0;
         fetch_c <= '0;
      end else if (req_valid_i && req_ready_o) begin
         va_c    <= req_va_i;
         flat_c  <= !en_i;
         fetch_c <= '0;
      end else if (mem_req_valid_o && mem_req_ready_i) begin
         fetch_c <= fetch_c + 2'd1;
      end
   end

   // R2: flat lookups issue no read and echo the address
   p_flat_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flat_c && !req_ready_o) |-> !mem_req_valid_o);

   p_flat_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && flat_c) |-> (rsp_pa_o == va_c && rsp_size_o == 3'd4 && !rsp_fault_o));

   // R3: first read address built from base and top index
   p_l1_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && fetch_c == 2'd0) |->
         (mem_addr_o == {tbl_base_i[ADDR_W-1:L1_ALIGN], va_c[ADDR_W-1:L1_SHIFT], 2'b00}));

   // R4 / R11: faults carry no address
   p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0 && rsp_size_o == 3'd0));

   // R6 / R7: section-sized results after a single read
   p_leaf_one_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_fault_o && (rsp_size_o == 3'd2 || rsp_size_o == 3'd3)) |->
         (fetch_c == 2'd1));

   // R9 / R10: page results after two reads
   p_page_two_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_fault_o && rsp_size_o <= 3'd1) |-> (fetch_c == 2'd2));

   // R12: handshake and response shape
   p_hold_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));

   p_max_two_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && mem_req_ready_i) |-> (fetch_c < 2'd2));

   p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |=> !rsp_valid_o);

   p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o || mem_req_valid_o) |-> !req_ready_o);

endmodule

bind xlat_walker xlat_walker_chk #(.ADDR_W(ADDR_W), .L1_IDX_W(L1_IDX_W)) u_chk (.*);

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic [31:0] tbl_base_i = '0;
   logic        req_valid_i = 1'b0;
   logic [31:0] req_va_i = '0;
   logic        req_ready_o;
   logic        rsp_valid_o;
   logic [31:0] rsp_pa_o;
   logic [2:0]  rsp_size_o;
   logic        rsp_fault_o;
   logic        mem_req_valid_o;
   logic        mem_req_ready_i = 1'b0;
   logic [31:0] mem_addr_o;
   logic        mem_rvalid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;

   always #10 clk = ~clk;

   xlat_walker dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .en_i            (en_i),
      .tbl_base_i      (tbl_base_i),
      .req_valid_i     (req_valid_i),
      .req_va_i        (req_va_i),
      .req_ready_o     (req_ready_o),
      .rsp_valid_o     (rsp_valid_o),
      .rsp_pa_o        (rsp_pa_o),
      .rsp_size_o      (rsp_size_o),
      .rsp_fault_o     (rsp_fault_o),
      .mem_req_valid_o (mem_req_valid_o),
      .mem_req_ready_i (mem_req_ready_i),
      .mem_addr_o      (mem_addr_o),
      .mem_rvalid_i    (mem_rvalid_i),
      .mem_rdata_i     (mem_rdata_i)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc = cyc + 1;

   // memory model state
   logic [31:0] l1_word = '0;
   logic [31:0] l2_word = '0;
   int          stall = 0;
   int          fetch_n = 0;
   int          wait_cnt = 0;
   int          stall_bad = 0;
   bit          hs = 1'b0;
   logic [31:0] first_addr = '0;
   logic [31:0] a1 = '0;
   logic [31:0] a2 = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_req_ready_i = 1'b0;
         mem_rvalid_i    = 1'b0;
         hs              = 1'b0;
         wait_cnt        = 0;
      end else if (hs) begin
         mem_req_ready_i = 1'b0;
         mem_rvalid_i    = 1'b1;
         mem_rdata_i     = (fetch_n == 1) ? l1_word : l2_word;
         hs              = 1'b0;
         wait_cnt        = 0;
      end else begin
         mem_rvalid_i = 1'b0;
         if (mem_req_valid_o) begin
            if (wait_cnt == 0) first_addr = mem_addr_o;
            else if (mem_addr_o !== first_addr) stall_bad = stall_bad + 1;
            if (wait_cnt >= stall) begin
               mem_req_ready_i = 1'b1;
               fetch_n = fetch_n + 1;
               if (fetch_n == 1) a1 = mem_addr_o;
               else a2 = mem_addr_o;
               hs = 1'b1;
            end else begin
               wait_cnt = wait_cnt + 1;
            end
         end
      end
   end

   // response monitor
   logic [31:0] r_pa = '0;
   logic [2:0]  r_size = '0;
   logic        r_fault = 1'b0;
   int          r_cnt = 0;
   int          r_cyc = 0;

   always @(negedge clk) begin
      if (rst_n && rsp_valid_o) begin
         r_pa    = rsp_pa_o;
         r_size  = rsp_size_o;
         r_fault = rsp_fault_o;
         r_cnt   = r_cnt + 1;
         r_cyc   = cyc;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   int   acc_cyc;
   int   rsp_seen;
   logic busy_seen;

   task automatic lookup(input logic [31:0] va, input logic en);
      int start;
      start       = r_cnt;
      fetch_n     = 0;
      stall_bad   = 0;
      en_i        = en;
      req_va_i    = va;
      req_valid_i = 1'b1;
      @(negedge clk);
      req_valid_i = 1'b0;
      acc_cyc     = cyc;
      busy_seen   = req_ready_o;
      for (int i = 0; i < 40 && r_cnt == start; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      rsp_seen = r_cnt - start;
   endtask

   task automatic t_reset;
      check("R1 req_ready", {31'd0, req_ready_o}, 32'd1);
      check("R1 rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
      check("R1 mem_req_valid", {31'd0, mem_req_valid_o}, 32'd0);
   endtask

   task automatic t_flat;
      tbl_base_i = 32'h8000_0000;
      lookup(32'hDEAD_BEEF, 1'b0);
      check("R2 pa", r_pa, 32'hDEAD_BEEF);
      check("R2 size", {29'd0, r_size}, 32'd4);
      check("R2 fault", {31'd0, r_fault}, 32'd0);
      check("R2 no reads", fetch_n, 32'd0);
      check("R2 latency", r_cyc - acc_cyc, 32'd0);
      check("R12 one pulse", rsp_seen, 32'd1);
   endtask

   task automatic t_section;
      tbl_base_i = 32'h8000_7ABC;
      l1_word    = 32'h9AB0_0002;
      stall      = 0;
      lookup(32'h4567_89AB, 1'b1);
      check("R3 l1 address", a1, 32'h8000_5158);
      check("R6 pa", r_pa, 32'h9AB7_89AB);
      check("R6 size", {29'd0, r_size}, 32'd2);
      check("R6 fault", {31'd0, r_fault}, 32'd0);
      check("R6 one read", fetch_n, 32'd1);
      check("R12 busy", {31'd0, busy_seen}, 32'd0);
   endtask

   task automatic t_super_stall;
      tbl_base_i = 32'h8000_4000;
      l1_word    = 32'h1204_0002;
      stall      = 3;
      lookup(32'h4567_89AB, 1'b1);
      check("R7 pa", r_pa, 32'h1267_89AB);
      check("R7 size", {29'd0, r_size}, 32'd3);
      check("R7 one read", fetch_n, 32'd1);
      check("R12 addr held", stall_bad, 32'd0);
      check("R12 one pulse", rsp_seen, 32'd1);
      stall = 0;
   endtask

   task automatic t_l1_faults;
      l1_word = 32'hFFFF_FFFC;
      lookup(32'h0123_4567, 1'b1);
      check("R4 fault", {31'd0, r_fault}, 32'd1);
      check("R4 pa", r_pa, 32'd0);
      check("R4 size", {29'd0, r_size}, 32'd0);
      check("R4 one read", fetch_n, 32'd1);
      l1_word = 32'h1230_0003;
      lookup(32'h0123_4567, 1'b1);
      check("R5 fault", {31'd0, r_fault}, 32'd1);
      check("R5 pa", r_pa, 32'd0);
      check("R5 one read", fetch_n, 32'd1);
   endtask

   task automatic t_small;
      tbl_base_i = 32'h0001_0000;
      l1_word    = 32'h4000_0C01;
      l2_word    = 32'h7654_3002;
      stall      = 1;
      lookup(32'h8012_3456, 1'b1);
      check("R3 l1 address", a1, 32'h0001_2004);
      check("R8 l2 address", a2, 32'h4000_0C8C);
      check("R9 pa", r_pa, 32'h7654_3456);
      check("R9 size", {29'd0, r_size}, 32'd0);
      check("R9 fault", {31'd0, r_fault}, 32'd0);
      check("R12 two reads", fetch_n, 32'd2);
      check("R12 addr held", stall_bad, 32'd0);
      stall = 0;
   endtask

   task automatic t_large;
      l2_word = 32'hABCD_E001;
      lookup(32'h8012_3456, 1'b1);
      check("R10 pa", r_pa, 32'hABCD_3456);
      check("R10 size", {29'd0, r_size}, 32'd1);
      check("R10 fault", {31'd0, r_fault}, 32'd0);
   endtask

   task automatic t_l2_faults;
      l2_word = 32'hABCD_E000;
      lookup(32'h8012_3456, 1'b1);
      check("R11 type00 fault", {31'd0, r_fault}, 32'd1);
      check("R11 type00 pa", r_pa, 32'd0);
      l2_word = 32'hABCD_E003;
      lookup(32'h8012_3456, 1'b1);
      check("R11 type11 fault", {31'd0, r_fault}, 32'd1);
      check("R11 type11 two reads", fetch_n, 32'd2);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flat();
      t_section();
      t_super_stall();
      t_l1_faults();
      t_small();
      t_large();
      t_l2_faults();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done   = 1'b1;
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule